// File: doc/BRIEF.md
# Banked UART Host Register Decoder

This block is the host-facing register interface of a single-channel enhanced UART. A host presents a 3-bit address with a write or read enable. The block works out which register that address reaches. The answer depends on the address and on the current contents of several control registers. With no bank override, eight basic slots are visible. Setting the top bit of the line-control register exposes the baud divisor in place of slots 0 and 1. Writing one particular key value into the line-control register exposes an extended bank: a feature register and four flow-control character words. A two-bit enable pair exposes a transmit-control and a trigger-level register at slots 6 and 7.

The block owns every writable control register and drives their values to the rest of the UART through output ports. Receive data, interrupt identity, line status, modem status and the FIFO ready status come in from outside and are only steered onto the read bus. The block also produces three one-cycle pulses. One marks a write that lands on the transmit data slot, one marks a write to the FIFO-control register, and one marks a read from the receive data slot. The transmitter, the FIFOs, the interrupt logic and the baud generator sit outside and react to these pulses.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset the line-control register reads 0x1D; interrupt-enable, modem-control, FIFO-control, feature, scratch, divisor (both bytes), the four flow words, transmit-control and trigger-level are all 0x00.
- R2: With line-control bit 7 at 0 and no other override active, reads of addresses 0 through 7 return, in order: receive data input, interrupt-enable, interrupt identity input, line-control, modem-control, line status input, modem status input, scratch.
- R3: In the basic map, writes to address 5 or 6 change no register.
- R4: While line-control bit 7 is 1 and line-control is not 0xBF, address 0 reads and writes divisor bits [7:0] and address 1 reads and writes divisor bits [15:8]. Writes at address 0 give no transmit-data pulse, and reads at address 0 give no receive-read pulse.
- R5: While line-control equals 0xBF, address 2 reaches the feature register, and addresses 4, 5, 6 and 7 reach flow words 0, 1, 2 and 3 (flow_o bits [8k+7:8k] for word k). Addresses 0 and 1 reach the divisor, and address 3 reaches line-control.
- R6: When feature bit 4 and modem-control bit 6 are both 1 and line-control is not 0xBF, address 6 reaches the transmit-control register and address 7 reaches the trigger-level register. This takes priority over R7.
- R7: When cs_all is 1, modem-control bit 2 is 1, modem-control bit 4 is 0, and neither R5 nor R6 applies, a read of address 7 returns the fifo_rdy input and a write to address 7 changes no register.
- R8: A write to modem-control updates bit 7 only while feature bit 4 is 1; bits 6:0 are always written.
- R9: tx_wr_stb is high for exactly the one cycle after a write clock edge on address 0 in the basic map. fifo_ctl_wr_stb does the same for a write to address 2 while line-control is not 0xBF, and that write also loads fifo_ctl_o. rx_rd_stb does the same for a read at address 0 in the basic map.
- R10: Addresses that the active bank does not remap behave as in the basic map. An example is address 2 reading interrupt identity while line-control is 0x80.
- R11: Registers change only on a clock edge where wr_en is 1; rdata follows addr and register state with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register slot address |
| wr_en | input | 1 | Write enable, sampled at the clock edge |
| rd_en | input | 1 | Read qualifier, used only for the receive-read pulse |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| cs_all | input | 1 | Broadcast-select qualifier for the FIFO ready slot |
| rx_data | input | 8 | Receive data from the receive FIFO |
| int_ident | input | 8 | Interrupt identity from the interrupt logic |
| line_stat | input | 8 | Line status |
| modem_stat | input | 8 | Modem status |
| fifo_rdy | input | 8 | FIFO ready status |
| tx_wr_stb | output | 1 | Pulse after a transmit-data write |
| fifo_ctl_wr_stb | output | 1 | Pulse after a FIFO-control write |
| rx_rd_stb | output | 1 | Pulse after a receive-data read |
| int_en_o | output | 8 | Interrupt-enable register |
| fifo_ctl_o | output | 8 | FIFO-control register |
| line_ctl_o | output | 8 | Line-control register |
| modem_ctl_o | output | 8 | Modem-control register |
| div_o | output | 16 | Baud divisor |
| feat_o | output | 8 | Feature register |
| flow_o | output | 32 | Four flow-control character words |
| xmit_ctl_o | output | 8 | Transmit-control register |
| trig_lvl_o | output | 8 | Trigger-level register |

## Verification
The assertions assume that wr_en and rd_en are low while reset is high. They also assume that addr, wdata and cs_all hold steady across each clock edge, so that the past-cycle terms in the strobe and protection properties refer to a real host access. The bench drives every input on the falling edge and lowers both enables between accesses. It steps the line-control register through 0x03, 0x80 and 0xBF and toggles the enable pair, the FIFO-ready qualifiers and feature bit 4. It sweeps all eight addresses in each state and compares the results against a shadow model built from the requirements.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

    localparam int DW        = 8;
    localparam int AW        = 3;
    localparam int N_FLOW    = 4;
    localparam int DIV_W     = 2 * DW;

    localparam logic [DW-1:0] ENH_KEY  = 8'hBF;
    localparam logic [DW-1:0] LINE_RST = 8'h1D;

    localparam int LC_DIV_BIT  = 7;
    localparam int FEAT_EN_BIT = 4;
    localparam int MC_PROT_BIT = 7;
    localparam int MC_TC_BIT   = 6;
    localparam int MC_FR_BIT   = 2;
    localparam int MC_LOOP_BIT = 4;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_DATA, SEL_IEN, SEL_IDFC, SEL_LCTL, SEL_MCTL,
        SEL_LSTAT, SEL_MSTAT, SEL_SCR, SEL_DLO, SEL_DHI, SEL_FEAT,
        SEL_FLOW0, SEL_FLOW1, SEL_FLOW2, SEL_FLOW3,
        SEL_TXC, SEL_TRIG, SEL_FRDY
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] int_en;
        logic [DW-1:0] line_ctl;
        logic [DW-1:0] modem_ctl;
        logic [DW-1:0] scratch;
        logic [DW-1:0] div_lo;
        logic [DW-1:0] div_hi;
        logic [DW-1:0] feat;
        logic [N_FLOW-1:0][DW-1:0] flow;
        logic [DW-1:0] xmit_ctl;
        logic [DW-1:0] trig_lvl;
    } ctl_regs_t;

    typedef struct packed {
        logic [DW-1:0] rx_data;
        logic [DW-1:0] int_ident;
        logic [DW-1:0] line_stat;
        logic [DW-1:0] modem_stat;
        logic [DW-1:0] fifo_rdy;
    } stat_in_t;

    function automatic reg_sel_e base_sel(input logic [AW-1:0] a);
        case (a)
            3'd0:    return SEL_DATA;
            3'd1:    return SEL_IEN;
            3'd2:    return SEL_IDFC;
            3'd3:    return SEL_LCTL;
            3'd4:    return SEL_MCTL;
            3'd5:    return SEL_LSTAT;
            3'd6:    return SEL_MSTAT;
            default: return SEL_SCR;
        endcase
    endfunction

    function automatic reg_sel_e flow_sel(input logic [AW-1:0] a);
        case (a[1:0])
            2'd0:    return SEL_FLOW0;
            2'd1:    return SEL_FLOW1;
            2'd2:    return SEL_FLOW2;
            default: return SEL_FLOW3;
        endcase
    endfunction

    function automatic logic is_read_only(input reg_sel_e s);
        return (s == SEL_LSTAT) || (s == SEL_MSTAT) || (s == SEL_FRDY);
    endfunction

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
    import uart_bank_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] line_ctl,
    input  logic          feat_en,
    input  logic          mc_tc,
    input  logic          mc_fr,
    input  logic          mc_loop,
    input  logic          cs_all,
    output reg_sel_e      rd_sel,
    output reg_sel_e      wr_sel
);

    logic key_hit, div_hit, tc_hit, fr_hit;
    reg_sel_e sel;

    always_comb begin
        key_hit = (line_ctl == ENH_KEY);
        div_hit = line_ctl[LC_DIV_BIT];
        tc_hit  = feat_en && mc_tc;
        fr_hit  = cs_all && mc_fr && !mc_loop;

        sel = base_sel(addr);
        if (fr_hit && addr == 3'd7)
            sel = SEL_FRDY;
        if (tc_hit && addr == 3'd6)
            sel = SEL_TXC;
        if (tc_hit && addr == 3'd7)
            sel = SEL_TRIG;
        if (div_hit && addr == 3'd0)
            sel = SEL_DLO;
        if (div_hit && addr == 3'd1)
            sel = SEL_DHI;
        if (key_hit && addr == 3'd2)
            sel = SEL_FEAT;
        if (key_hit && addr[2])
            sel = flow_sel(addr);

        rd_sel = sel;
        wr_sel = is_read_only(sel) ? SEL_NONE : sel;
    end

endmodule

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
    import uart_bank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    input  reg_sel_e      wr_sel,
    input  reg_sel_e      rd_sel,
    output ctl_regs_t     regs,
    output logic [DW-1:0] fifo_ctl,
    output logic          tx_wr_stb,
    output logic          fifo_ctl_wr_stb,
    output logic          rx_rd_stb
);

    logic [DW-1:0] int_en_q, line_q, modem_q, scr_q, dlo_q, dhi_q;
    logic [DW-1:0] feat_q, txc_q, trig_q, fctl_q;
    logic [DW-1:0] flow_q [N_FLOW];
    logic [DW-1:0] modem_nx;

    always_comb begin
        modem_nx = wdata;
        if (!feat_q[FEAT_EN_BIT])
            modem_nx[MC_PROT_BIT] = modem_q[MC_PROT_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_en_q <= '0;
            line_q   <= LINE_RST;
            modem_q  <= '0;
            scr_q    <= '0;
            dlo_q    <= '0;
            dhi_q    <= '0;
            feat_q   <= '0;
            txc_q    <= '0;
            trig_q   <= '0;
            fctl_q   <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_IEN:  int_en_q <= wdata;
                SEL_IDFC: fctl_q   <= wdata;
                SEL_LCTL: line_q   <= wdata;
                SEL_MCTL: modem_q  <= modem_nx;
                SEL_SCR:  scr_q    <= wdata;
                SEL_DLO:  dlo_q    <= wdata;
                SEL_DHI:  dhi_q    <= wdata;
                SEL_FEAT: feat_q   <= wdata;
                SEL_TXC:  txc_q    <= wdata;
                SEL_TRIG: trig_q   <= wdata;
                default:  ;
            endcase
        end
    end

    for (genvar g = 0; g < N_FLOW; g++) begin : g_flow
        localparam logic [4:0] CODE = 5'(SEL_FLOW0) + 5'(g);
        always_ff @(posedge clk) begin
            if (rst)
                flow_q[g] <= '0;
            else if (wr_en && wr_sel == reg_sel_e'(CODE))
                flow_q[g] <= wdata;
        end
        assign regs.flow[g] = flow_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_wr_stb       <= 1'b0;
            fifo_ctl_wr_stb <= 1'b0;
            rx_rd_stb       <= 1'b0;
        end else begin
            tx_wr_stb       <= wr_en && (wr_sel == SEL_DATA);
            fifo_ctl_wr_stb <= wr_en && (wr_sel == SEL_IDFC);
            rx_rd_stb       <= rd_en && (rd_sel == SEL_DATA);
        end
    end

    assign regs.int_en    = int_en_q;
    assign regs.line_ctl  = line_q;
    assign regs.modem_ctl = modem_q;
    assign regs.scratch   = scr_q;
    assign regs.div_lo    = dlo_q;
    assign regs.div_hi    = dhi_q;
    assign regs.feat      = feat_q;
    assign regs.xmit_ctl  = txc_q;
    assign regs.trig_lvl  = trig_q;
    assign fifo_ctl       = fctl_q;

    // R8
    modem_prot_chk: assert property (@(posedge clk) disable iff (rst)
        (modem_q[MC_PROT_BIT] != $past(modem_q[MC_PROT_BIT])) |->
            ($past(feat_q[FEAT_EN_BIT]) && $past(wr_en)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ($stable(line_q) && $stable(modem_q) && $stable(feat_q)));

    // R9
    tx_stb_chk: assert property (@(posedge clk) disable iff (rst)
        tx_wr_stb |-> $past(wr_en));

    // R9
    rx_stb_chk: assert property (@(posedge clk) disable iff (rst)
        rx_rd_stb |-> $past(rd_en));

endmodule

// File: rtl/uart_rd_mux.sv
module uart_rd_mux
    import uart_bank_pkg::*;
(
    input  reg_sel_e      rd_sel,
    input  ctl_regs_t     regs,
    input  stat_in_t      stat,
    output logic [DW-1:0] rdata
);

    always_comb begin
        case (rd_sel)
            SEL_DATA:  rdata = stat.rx_data;
            SEL_IEN:   rdata = regs.int_en;
            SEL_IDFC:  rdata = stat.int_ident;
            SEL_LCTL:  rdata = regs.line_ctl;
            SEL_MCTL:  rdata = regs.modem_ctl;
            SEL_LSTAT: rdata = stat.line_stat;
            SEL_MSTAT: rdata = stat.modem_stat;
            SEL_SCR:   rdata = regs.scratch;
            SEL_DLO:   rdata = regs.div_lo;
            SEL_DHI:   rdata = regs.div_hi;
            SEL_FEAT:  rdata = regs.feat;
            SEL_FLOW0: rdata = regs.flow[0];
            SEL_FLOW1: rdata = regs.flow[1];
            SEL_FLOW2: rdata = regs.flow[2];
            SEL_FLOW3: rdata = regs.flow[3];
            SEL_TXC:   rdata = regs.xmit_ctl;
            SEL_TRIG:  rdata = regs.trig_lvl;
            SEL_FRDY:  rdata = stat.fifo_rdy;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
    import uart_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 cs_all,
    input  logic [DW-1:0]        rx_data,
    input  logic [DW-1:0]        int_ident,
    input  logic [DW-1:0]        line_stat,
    input  logic [DW-1:0]        modem_stat,
    input  logic [DW-1:0]        fifo_rdy,
    output logic                 tx_wr_stb,
    output logic                 fifo_ctl_wr_stb,
    output logic                 rx_rd_stb,
    output logic [DW-1:0]        int_en_o,
    output logic [DW-1:0]        fifo_ctl_o,
    output logic [DW-1:0]        line_ctl_o,
    output logic [DW-1:0]        modem_ctl_o,
    output logic [DIV_W-1:0]     div_o,
    output logic [DW-1:0]        feat_o,
    output logic [N_FLOW*DW-1:0] flow_o,
    output logic [DW-1:0]        xmit_ctl_o,
    output logic [DW-1:0]        trig_lvl_o
);

    ctl_regs_t regs;
    stat_in_t  stat;
    reg_sel_e  rd_sel, wr_sel;

    assign stat = '{rx_data: rx_data, int_ident: int_ident, line_stat: line_stat,
                    modem_stat: modem_stat, fifo_rdy: fifo_rdy};

    uart_bank_decode u_dec (
        .addr     (addr),
        .line_ctl (regs.line_ctl),
        .feat_en  (regs.feat[FEAT_EN_BIT]),
        .mc_tc    (regs.modem_ctl[MC_TC_BIT]),
        .mc_fr    (regs.modem_ctl[MC_FR_BIT]),
        .mc_loop  (regs.modem_ctl[MC_LOOP_BIT]),
        .cs_all   (cs_all),
        .rd_sel   (rd_sel),
        .wr_sel   (wr_sel)
    );

    uart_ctl_regs u_regs (
        .clk             (clk),
        .rst             (rst),
        .wr_en           (wr_en),
        .rd_en           (rd_en),
        .wdata           (wdata),
        .wr_sel          (wr_sel),
        .rd_sel          (rd_sel),
        .regs            (regs),
        .fifo_ctl        (fifo_ctl_o),
        .tx_wr_stb       (tx_wr_stb),
        .fifo_ctl_wr_stb (fifo_ctl_wr_stb),
        .rx_rd_stb       (rx_rd_stb)
    );

    uart_rd_mux u_mux (
        .rd_sel (rd_sel),
        .regs   (regs),
        .stat   (stat),
        .rdata  (rdata)
    );

    assign int_en_o    = regs.int_en;
    assign line_ctl_o  = regs.line_ctl;
    assign modem_ctl_o = regs.modem_ctl;
    assign div_o       = {regs.div_hi, regs.div_lo};
    assign feat_o      = regs.feat;
    assign flow_o      = regs.flow;
    assign xmit_ctl_o  = regs.xmit_ctl;
    assign trig_lvl_o  = regs.trig_lvl;

    // R5
    feat_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (line_ctl_o == ENH_KEY && addr == 3'd2) |-> (rdata == feat_o));

    // R4
    div_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (line_ctl_o[LC_DIV_BIT] && addr == 3'd0) |-> (rdata == div_o[DW-1:0]));

    // R7
    frdy_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_all && modem_ctl_o[MC_FR_BIT] && !modem_ctl_o[MC_LOOP_BIT] &&
         !(feat_o[FEAT_EN_BIT] && modem_ctl_o[MC_TC_BIT]) &&
         line_ctl_o != ENH_KEY && addr == 3'd7) |-> (rdata == fifo_rdy));

    // R3
    stat_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd5 && line_ctl_o != ENH_KEY) |=>
            (line_ctl_o == $past(line_ctl_o) && modem_ctl_o == $past(modem_ctl_o) &&
             int_en_o == $past(int_en_o) && div_o == $past(div_o)));

endmodule

// File: tb/uart_bank_regs_tb.sv
module uart_bank_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        cs_all = 1'b0;
    logic [7:0]  rx_data = 8'hA1, int_ident = 8'hC2, line_stat = 8'h60;
    logic [7:0]  modem_stat = 8'hB0, fifo_rdy = 8'h5A;
    logic        tx_wr_stb, fifo_ctl_wr_stb, rx_rd_stb;
    logic [7:0]  int_en_o, fifo_ctl_o, line_ctl_o, modem_ctl_o, feat_o;
    logic [15:0] div_o;
    logic [31:0] flow_o;
    logic [7:0]  xmit_ctl_o, trig_lvl_o;

    int n_chk = 0;
    int n_err = 0;

    // shadow model
    logic [7:0] m_ien = 0, m_fctl = 0, m_lcr = 8'h1D, m_mcr = 0, m_scr = 0;
    logic [7:0] m_dlo = 0, m_dhi = 0, m_feat = 0, m_txc = 0, m_trig = 0;
    logic [7:0] m_flow [4] = '{default: 8'h00};

    always #10 clk = ~clk;

    uart_bank_regs u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .cs_all(cs_all), .rx_data(rx_data),
        .int_ident(int_ident), .line_stat(line_stat), .modem_stat(modem_stat),
        .fifo_rdy(fifo_rdy), .tx_wr_stb(tx_wr_stb), .fifo_ctl_wr_stb(fifo_ctl_wr_stb),
        .rx_rd_stb(rx_rd_stb), .int_en_o(int_en_o), .fifo_ctl_o(fifo_ctl_o),
        .line_ctl_o(line_ctl_o), .modem_ctl_o(modem_ctl_o), .div_o(div_o),
        .feat_o(feat_o), .flow_o(flow_o), .xmit_ctl_o(xmit_ctl_o), .trig_lvl_o(trig_lvl_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic key_on();  return m_lcr == 8'hBF; endfunction
    function automatic logic tc_on();   return m_feat[4] && m_mcr[6]; endfunction
    function automatic logic fr_on();   return cs_all && m_mcr[2] && !m_mcr[4]; endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        if (key_on() && a == 3'd2) return m_feat;
        if (key_on() && a[2]) return m_flow[a[1:0]];
        if (m_lcr[7] && a == 3'd0) return m_dlo;
        if (m_lcr[7] && a == 3'd1) return m_dhi;
        if (tc_on() && a == 3'd6) return m_txc;
        if (tc_on() && a == 3'd7) return m_trig;
        if (fr_on() && a == 3'd7) return fifo_rdy;
        case (a)
            3'd0: return rx_data;
            3'd1: return m_ien;
            3'd2: return int_ident;
            3'd3: return m_lcr;
            3'd4: return m_mcr;
            3'd5: return line_stat;
            3'd6: return modem_stat;
            default: return m_scr;
        endcase
    endfunction

    task automatic model_wr(input logic [2:0] a, input logic [7:0] d);
        if (key_on() && a == 3'd2) m_feat = d;
        else if (key_on() && a[2]) m_flow[a[1:0]] = d;
        else if (m_lcr[7] && a == 3'd0) m_dlo = d;
        else if (m_lcr[7] && a == 3'd1) m_dhi = d;
        else if (tc_on() && a == 3'd6) m_txc = d;
        else if (tc_on() && a == 3'd7) m_trig = d;
        else if (fr_on() && a == 3'd7) ;
        else case (a)
            3'd1: m_ien = d;
            3'd2: m_fctl = d;
            3'd3: m_lcr = d;
            3'd4: m_mcr = {m_feat[4] ? d[7] : m_mcr[7], d[6:0]};
            3'd7: m_scr = d;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        logic etx, efc;
        etx = (a == 3'd0) && !m_lcr[7];
        efc = (a == 3'd2) && !key_on();
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        model_wr(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        chk(tx_wr_stb == etx, {tag, " R9 tx pulse"}, tx_wr_stb, etx);
        chk(fifo_ctl_wr_stb == efc, {tag, " R9 fctl pulse"}, fifo_ctl_wr_stb, efc);
        @(negedge clk);
        chk(!tx_wr_stb && !fifo_ctl_wr_stb, {tag, " R9 pulse width"},
            {tx_wr_stb, fifo_ctl_wr_stb}, 0);
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        logic erx;
        erx = (a == 3'd0) && !m_lcr[7];
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        chk(rdata == exp_rd(a), {tag, $sformatf(" read addr %0d", a)}, rdata, exp_rd(a));
        @(negedge clk);
        rd_en = 1'b0;
        chk(rx_rd_stb == erx, {tag, " R9 rx pulse"}, rx_rd_stb, erx);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 8; a++) rd(3'(a), tag);
    endtask

    task automatic chk_ports(input string tag);
        chk(int_en_o == m_ien, {tag, " int_en_o"}, int_en_o, m_ien);
        chk(fifo_ctl_o == m_fctl, {tag, " fifo_ctl_o"}, fifo_ctl_o, m_fctl);
        chk(line_ctl_o == m_lcr, {tag, " line_ctl_o"}, line_ctl_o, m_lcr);
        chk(modem_ctl_o == m_mcr, {tag, " modem_ctl_o"}, modem_ctl_o, m_mcr);
        chk(div_o == {m_dhi, m_dlo}, {tag, " div_o"}, div_o, {m_dhi, m_dlo});
        chk(feat_o == m_feat, {tag, " feat_o"}, feat_o, m_feat);
        chk(flow_o == {m_flow[3], m_flow[2], m_flow[1], m_flow[0]}, {tag, " flow_o"},
            flow_o, {m_flow[3], m_flow[2], m_flow[1], m_flow[0]});
        chk(xmit_ctl_o == m_txc, {tag, " xmit_ctl_o"}, xmit_ctl_o, m_txc);
        chk(trig_lvl_o == m_trig, {tag, " trig_lvl_o"}, trig_lvl_o, m_trig);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        chk(line_ctl_o == 8'h1D, "R1 line_ctl reset", line_ctl_o, 8'h1D);
        chk_ports("R1 reset");
        sweep("R1 R2 reset map");

        // R2 basic map with distinct contents
        wr(3'd3, 8'h03, "R2");
        wr(3'd1, 8'h0F, "R2");
        wr(3'd7, 8'h77, "R2");
        // R8 protected bit with feature bit 4 clear
        wr(3'd4, 8'h83, "R8");
        chk(modem_ctl_o == 8'h03, "R8 bit7 blocked", modem_ctl_o, 8'h03);
        sweep("R2 base");

        // R3 read-only slots
        wr(3'd5, 8'hFF, "R3");
        wr(3'd6, 8'hFF, "R3");
        chk_ports("R3 after status writes");
        sweep("R3 base");

        // R9 pulses and FIFO-control load
        wr(3'd0, 8'h55, "R9 tx");
        wr(3'd2, 8'hC7, "R9 fctl");
        chk(fifo_ctl_o == 8'hC7, "R9 fifo_ctl_o", fifo_ctl_o, 8'hC7);
        rd(3'd0, "R9 rx");

        // R4 divisor bank, R10 fall-through
        wr(3'd3, 8'h80, "R4");
        wr(3'd0, 8'h34, "R4");
        wr(3'd1, 8'h12, "R4");
        chk(div_o == 16'h1234, "R4 div_o", div_o, 16'h1234);
        chk(int_en_o == 8'h0F, "R4 int_en untouched", int_en_o, 8'h0F);
        sweep("R4 R10 divisor bank");

        // R5 enhanced bank
        wr(3'd3, 8'hBF, "R5");
        wr(3'd2, 8'h10, "R5");
        for (int k = 0; k < 4; k++) wr(3'(4 + k), 8'(8'h11 * (k + 1)), "R5");
        chk(flow_o == 32'h44332211, "R5 flow_o", flow_o, 32'h44332211);
        chk(fifo_ctl_o == 8'hC7, "R5 fifo_ctl untouched", fifo_ctl_o, 8'hC7);
        sweep("R5 enhanced bank");

        // R8 with feature bit 4 set; R6 bank
        wr(3'd3, 8'h03, "R6");
        wr(3'd4, 8'hC0, "R8");
        chk(modem_ctl_o == 8'hC0, "R8 bit7 allowed", modem_ctl_o, 8'hC0);
        wr(3'd6, 8'h9A, "R6");
        wr(3'd7, 8'h0B, "R6");
        chk(xmit_ctl_o == 8'h9A && trig_lvl_o == 8'h0B, "R6 tc/tl ports",
            {xmit_ctl_o, trig_lvl_o}, 16'h9A0B);
        chk(m_scr == 8'h77 && modem_stat == 8'hB0, "R6 bench sanity", m_scr, 8'h77);
        sweep("R6 tc bank");
        wr(3'd3, 8'h80, "R10");
        sweep("R6 R10 divisor plus tc");

        // R7 FIFO ready slot and its priority
        wr(3'd3, 8'h03, "R7");
        cs_all = 1'b1;
        wr(3'd4, 8'h44, "R7");
        sweep("R7 tc over fifo ready");
        wr(3'd4, 8'h04, "R7");
        sweep("R7 fifo ready");
        wr(3'd7, 8'hEE, "R7");
        cs_all = 1'b0;
        sweep("R7 scratch kept");
        cs_all = 1'b1;
        wr(3'd4, 8'h14, "R7");
        sweep("R7 loopback blocks");
        cs_all = 1'b0;

        // R8 protection after clearing feature bit 4
        wr(3'd4, 8'h80, "R8");
        wr(3'd3, 8'hBF, "R8");
        wr(3'd2, 8'h00, "R8");
        wr(3'd3, 8'h03, "R8");
        wr(3'd4, 8'h01, "R8");
        chk(modem_ctl_o == 8'h81, "R8 bit7 held", modem_ctl_o, 8'h81);
        wr(3'd4, 8'h00, "R8");
        chk(modem_ctl_o == 8'h80, "R8 low bits written", modem_ctl_o, 8'h80);

        // R11 write visible next cycle, final sweeps across modes
        for (int m = 0; m < 3; m++) begin
            wr(3'd3, (m == 0) ? 8'h03 : (m == 1) ? 8'h80 : 8'hBF, "R11");
            sweep("R11 mode sweep");
            chk_ports("R11 mode ports");
        end
        summary();
    end

endmodule